// File: doc/BRIEF.md
# Bus Line Direction Controller

This block sits beside one bidirectional line of a parallel, multi-master shared bus that supports bursts. The bus interface logic on the board never says which way data is moving on that line. The block works the direction out from the frame, initiator-ready, target-ready and grant controls, together with the low command bit. From that it drives two enables: one for the line's transmitter and one for its receiver.

When a transaction opens, the block records two facts: whether this board won the bus, and whether the command is a write. It then follows the transaction through its address cycle, an optional turnaround and one or more data phases. Both enables drop as soon as the final data item has moved.

The current state is held in a register. A 2-to-1 selector then chooses between the master-side and target-side reading of that state. Because of this, each enable applies to the same bus cycle whose controls produced it, with no added delay.

Top module: `line_dir_ctl`

## Requirements
- R1: After reset, and in every cycle with no transaction open, both enables are low. Activity on initiator-ready or target-ready while frame is high and no transaction is open has no effect on them.
- R2: A cycle where frame (active low) is low and no transaction is open is the address cycle. In that cycle, txActive is high and rxActive is low when the local grant (active low) is low. Otherwise rxActive is high and txActive is low.
- R3: At the clock that ends the address cycle, the block latches the command bit (1 = write, 0 = read) and whether the grant was low (local board is master). Both values hold until the transaction ends, and later changes of grant or command bit have no effect.
- R4: In the data phases of a write, the master has txActive high and rxActive low, and the target has rxActive high and txActive low.
- R5: After the address cycle of a read there are TURN_CYCLES cycles (default 1) with both enables low. In the read data phases that follow, the master has rxActive high and the target has txActive high.
- R6: A wait cycle in a data phase (initiator-ready or target-ready high) keeps the data-phase enables unchanged.
- R7: The transaction ends at the first clock where frame is high and both initiator-ready and target-ready are low. That cycle still shows the data-phase enables, and both enables are low from the next cycle on.
- R8: txActive and rxActive are never high in the same cycle.
- R9: A new address cycle may follow the ending cycle immediately, with no idle cycle between, and is decoded as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Transaction frame, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| gntN | input | 1 | Local bus grant, active low |
| cmdBit | input | 1 | Low command bit during the address cycle, 1 = write |
| txActive | output | 1 | Transmitter enable for the line |
| rxActive | output | 1 | Receiver enable for the line |

## Verification
The enables are combinational from the registered phase and the live controls, so each result is due in the same cycle as the stimulus that causes it. Latched role effects appear from the cycle after the address cycle. The bench drives each cycle's controls on the falling edge and compares the enables one time unit later, still before the next rising edge. This means every comparison sees the phase register updated by the previous edge plus the current inputs. Expected values come from the cycle's position in the burst, computed from master/target, read/write, burst length, wait placement and idle gap.

// File: rtl/line_dir_pkg.sv
package line_dir_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TURN = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Strobes passed from the sequencer to the direction datapath.
  typedef struct packed {
    logic addrPhase;  // current cycle is an address cycle
    logic turnPhase;  // current cycle is a read turnaround
    logic dataPhase;  // current cycle is inside the data phases
    logic latchRole;  // capture command and grant at this edge
    logic clearRole;  // transaction finishes at this edge
  } dir_strobe_t;

endpackage

// File: rtl/line_dir_fsm.sv
module line_dir_fsm
  import line_dir_pkg::*;
#(
  parameter int TURN_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        trdyN,
  input  logic        cmdBit,
  output dir_strobe_t strb
);

  localparam int TW = (TURN_CYCLES > 1) ? $clog2(TURN_CYCLES) : 1;
  localparam logic [TW-1:0] TURN_LAST = TW'(TURN_CYCLES - 1);

  phase_t        phase, phaseNext;
  logic [TW-1:0] turnCnt, turnCntNext;
  logic          openTxn;
  logic          doneXfer;

  assign openTxn  = (phase == PH_IDLE) && !frameN;
  assign doneXfer = (phase != PH_IDLE) && frameN && !irdyN && !trdyN;

  always_comb begin
    phaseNext   = phase;
    turnCntNext = turnCnt;
    unique case (phase)
      PH_IDLE: begin
        if (openTxn) begin
          phaseNext   = cmdBit ? PH_DATA : PH_TURN;
          turnCntNext = '0;
        end
      end
      PH_TURN: begin
        if (doneXfer) begin
          phaseNext = PH_IDLE;
        end else if (turnCnt == TURN_LAST) begin
          phaseNext = PH_DATA;
        end else begin
          turnCntNext = turnCnt + 1'b1;
        end
      end
      PH_DATA: begin
        if (doneXfer) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      turnCnt <= '0;
    end else begin
      phase   <= phaseNext;
      turnCnt <= turnCntNext;
    end
  end

  always_comb begin
    strb.addrPhase = openTxn;
    strb.turnPhase = (phase == PH_TURN);
    strb.dataPhase = (phase == PH_DATA);
    strb.latchRole = openTxn;
    strb.clearRole = doneXfer;
  end

endmodule

// File: rtl/line_dir_path.sv
module line_dir_path
  import line_dir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        gntN,
  input  logic        cmdBit,
  input  dir_strobe_t strb,
  output logic        txActive,
  output logic        rxActive
);

  logic roleMaster;
  logic roleWrite;
  logic masterNow;
  logic masterDrives;
  logic targetDrives;

  // Registered stage: role of this board and command kind.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roleMaster <= 1'b0;
      roleWrite  <= 1'b0;
    end else if (strb.latchRole) begin
      roleMaster <= !gntN;
      roleWrite  <= cmdBit;
    end else if (strb.clearRole) begin
      roleMaster <= 1'b0;
      roleWrite  <= 1'b0;
    end
  end

  // Master-side and target-side interpretation of the current phase.
  assign masterDrives = strb.addrPhase || (strb.dataPhase && roleWrite);
  assign targetDrives = strb.dataPhase && !roleWrite;

  // During the address cycle the role is not latched yet, so use the live grant.
  assign masterNow = strb.addrPhase ? !gntN : roleMaster;

  // 2-to-1 selector between the two interpretations.
  assign txActive = masterNow ? masterDrives : targetDrives;
  assign rxActive = (strb.addrPhase || strb.dataPhase) && !txActive;

endmodule

// File: rtl/line_dir_ctl.sv
module line_dir_ctl
  import line_dir_pkg::*;
#(
  parameter int TURN_CYCLES = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameN,
  input  logic irdyN,
  input  logic trdyN,
  input  logic gntN,
  input  logic cmdBit,
  output logic txActive,
  output logic rxActive
);

  dir_strobe_t strb;

  line_dir_fsm #(.TURN_CYCLES(TURN_CYCLES)) fsm_i (
    .clk    (clk),
    .rstN   (rstN),
    .frameN (frameN),
    .irdyN  (irdyN),
    .trdyN  (trdyN),
    .cmdBit (cmdBit),
    .strb   (strb)
  );

  line_dir_path path_i (
    .clk      (clk),
    .rstN     (rstN),
    .gntN     (gntN),
    .cmdBit   (cmdBit),
    .strb     (strb),
    .txActive (txActive),
    .rxActive (rxActive)
  );

endmodule

// File: rtl/line_dir_chk.sv
module line_dir_chk
  import line_dir_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        frameN,
  input logic        irdyN,
  input logic        trdyN,
  input logic        gntN,
  input logic        cmdBit,
  input logic        txActive,
  input logic        rxActive,
  input dir_strobe_t strb
);

  // R8: the two enables never overlap
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(txActive && rxActive));

  // R7: after the ending clock nothing stays enabled unless a new frame opens
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    (frameN && !irdyN && !trdyN && (txActive || rxActive || strb.turnPhase))
      |=> (!frameN || (!txActive && !rxActive)));

  // R5: a read address cycle is followed by a quiet turnaround
  a_r5_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrPhase && !cmdBit) |=> (strb.turnPhase && !txActive && !rxActive));

  // R3 / R4: first write data cycle follows the role captured at the address edge
  a_r4_write_role: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrPhase && cmdBit) |=> (strb.dataPhase && (txActive == $past(!gntN))));

  // R2: phase strobes are mutually exclusive
  a_r2_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.addrPhase, strb.turnPhase, strb.dataPhase}));

endmodule

bind line_dir_ctl line_dir_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .frameN   (frameN),
  .irdyN    (irdyN),
  .trdyN    (trdyN),
  .gntN     (gntN),
  .cmdBit   (cmdBit),
  .txActive (txActive),
  .rxActive (rxActive),
  .strb     (strb)
);

// File: tb/line_dir_ctl_tb_top.sv
`timescale 1ns/1ps
module line_dir_ctl_tb_top;

  localparam int TURN = 1;

  logic clk = 1'b0;
  logic rstN, frameN, irdyN, trdyN, gntN, cmdBit;
  logic txActive, rxActive;
  int   nChecks = 0;
  int   nFail   = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  line_dir_ctl #(.TURN_CYCLES(TURN)) dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .gntN(gntN), .cmdBit(cmdBit), .txActive(txActive), .rxActive(rxActive)
  );

  task automatic check(input logic eTx, input logic eRx, input string tag);
    nChecks++;
    if (txActive !== eTx || rxActive !== eRx) begin
      nFail++;
      $display("FAIL %s: tx/rx actual %b%b expected %b%b at %0t",
               tag, txActive, rxActive, eTx, eRx, $time);
    end
    nChecks++;
    if (txActive === 1'b1 && rxActive === 1'b1) begin
      nFail++;
      $display("FAIL R8: tx/rx actual 11 expected not both high at %0t", $time);
    end
  endtask

  task automatic step(input logic f, input logic i, input logic t, input logic g,
                      input logic c, input logic eTx, input logic eRx, input string tag);
    @(negedge clk);
    frameN = f; irdyN = i; trdyN = t; gntN = g; cmdBit = c;
    #1;
    check(eTx, eRx, tag);
  endtask

  // waitKind: 0 none, 1 initiator wait, 2 target wait (placed on first data phase)
  task automatic runTxn(input bit m, input bit w, input int n, input int waitKind,
                        input bit gap, input bit afterNoGap);
    logic dTx;
    logic gOther;
    dTx    = (m == w);
    gOther = m ? 1'b1 : 1'b0;  // grant flips after address: R3
    step(1'b0, 1'b1, 1'b1, !m, w, m, !m, afterNoGap ? "R9 address" : "R2 address");
    if (!w) begin
      for (int k = 0; k < TURN; k++)
        step(1'b0, 1'b0, 1'b1, gOther, !w, 1'b0, 1'b0, "R5 turnaround");
    end
    for (int k = 0; k < n; k++) begin
      bit last;
      last = (k == n - 1);
      if (waitKind == 1 && k == 0)
        step(1'b0, 1'b1, 1'b0, gOther, !w, dTx, !dTx, "R6 initiator wait");
      if (waitKind == 2 && k == 0)
        step(last ? 1'b1 : 1'b0, 1'b0, 1'b1, gOther, !w, dTx, !dTx, "R6 target wait");
      step(last ? 1'b1 : 1'b0, 1'b0, 1'b0, gOther, !w, dTx, !dTx,
           last ? "R7 final item" : (w ? "R4 R3 write data" : "R5 R3 read data"));
    end
    if (gap)
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1 R7 idle after end");
  endtask

  initial begin
    #150000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    bit prevGap;
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; trdyN = 1'b1; gntN = 1'b1; cmdBit = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(1'b0, 1'b0, "R1 reset");
    @(negedge clk);
    rstN = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 idle");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1 ready strobes ignored");
    prevGap = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int n = 1; n <= 4; n++)
          for (int wk = 0; wk < 3; wk++) begin
            bit gap;
            gap = ((n + wk) % 2) == 0;
            runTxn(m[0], w[0], n, wk, gap, !prevGap);
            prevGap = gap;
          end
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1 R7 final idle");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R1 final idle");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule